// File: doc/BRIEF.md
# Cell Phase Offset Measurement Unit

This block measures how far an incoming cell boundary sits from the local reference timing. Its output is an 11-bit delay-control word that steers a binary-weighted delay line. The coarse part counts whole bit periods. A cell-start strobe clears a 9-bit counter and arms it. The counter then advances on every bit clock. The first reference strobe after arming freezes the count into the upper nine bits of the word.

The fine part resolves the offset below one bit period. Four sample bits come from taps spaced 100 ps apart; the analog sampling that produces them happens outside this block. These bits form a thermometer pattern, which is turned into two low-order control bits. The word therefore counts the delay in quarter-bit steps. The most significant bit is worth half the cell-clock period, and each lower bit is worth half of the bit above it. A fine pattern that is not a thermometer pattern raises an error flag.

The word changes only once per cell. Each change comes with a one-cycle valid pulse.

Top module: `cell_phase_meter`

## Requirements
- R1: While `rstN` is low, `ctrlWord`, `ctrlValid` and `fineErr` are all 0.
- R2: A cycle with `cellStart` high clears the coarse counter and arms it. While armed, the counter advances by one on every clock. A `refStrobe` that arrives k cycles after the `cellStart` cycle (k >= 1) therefore captures the coarse value k-1.
- R3: The capture happens on the clock edge at the end of the armed `refStrobe` cycle. In the cycle after that edge, `ctrlValid` is high for exactly one cycle. The counter then disarms.
- R4: `fineTaps[0]` is the earliest tap and `fineTaps[3]` the latest. The captured fine code sits in `ctrlWord[1:0]`. Patterns {fineTaps[0..3]} map as follows: 0000 gives 00, 1000 gives 00, 1100 gives 01, 1110 gives 10 and 1111 gives 11.
- R5: A fine pattern that is not a thermometer pattern, for example fineTaps[1] set with fineTaps[0] clear, gives fine code 00 and sets `fineErr` to 1 at the same update. A valid pattern clears `fineErr` at its update.
- R6: If no reference strobe arrives, the coarse counter stops at 511 and does not wrap.
- R7: Between updates, `ctrlWord` and `fineErr` hold their values. A `refStrobe` while the counter is not armed changes nothing and gives no valid pulse.
- R8: If `cellStart` and `refStrobe` are both high in the same cycle, the restart wins. No capture occurs, and counting restarts from 0.
- R9: `ctrlWord[10:2]` holds the coarse count with bit 10 as its MSB. The unsigned word value equals 4 × coarse + fine, which is the delay in quarter-bit units.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cellStart | input | 1 | Cell-boundary strobe; restarts measurement |
| refStrobe | input | 1 | Reference-edge strobe; triggers capture |
| fineTaps | input | 4 | Captured sub-bit samples, bit 0 earliest |
| ctrlWord | output | 11 | Delay-control word, bit 10 heaviest |
| ctrlValid | output | 1 | One-cycle pulse on each word update |
| fineErr | output | 1 | Last captured fine pattern was not a thermometer code |

## Verification
The assertions check on every cycle that a valid pulse never lasts two cycles and that it always follows a reference strobe without a coincident restart. They also check that the word and the error flag hold steady outside valid cycles, and that an error always comes with a zero fine code. Only the bench scenarios can show that the captured count matches the elapsed cycles, that the counter saturates, and that each fine pattern maps to the right code. A behavioural model compared on every clock covers these, and directed cells exercise short, long, overflowing, coincident and unarmed cases.

// File: rtl/phase_meter_pkg.sv
package phase_meter_pkg;
  typedef struct packed {
    logic clrCnt;
    logic incCnt;
    logic capture;
  } meterStrobes_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } meterState_t;
endpackage

// File: rtl/fine_therm_enc.sv
module fine_therm_enc #(
  parameter int TAPS = 4,
  localparam int CODE_W = $clog2(TAPS),
  localparam int ONES_W = $clog2(TAPS + 1)
) (
  input  logic [TAPS-1:0]   taps,
  output logic [CODE_W-1:0] code,
  output logic              illegal
);
  logic [ONES_W-1:0] ones;
  logic              legal;

  always_comb begin
    ones = '0;
    for (int i = 0; i < TAPS; i++) begin
      ones = ones + ONES_W'(taps[i]);
    end
  end

  // A thermometer filled from bit 0 has no set bit above a clear one
  assign legal   = ((taps & (taps + TAPS'(1))) == '0);
  assign illegal = !legal;

  always_comb begin
    if (legal && ones != '0) begin
      code = CODE_W'(ones - ONES_W'(1));
    end else begin
      code = '0;
    end
  end
endmodule

// File: rtl/phase_meter_ctrl.sv
module phase_meter_ctrl
  import phase_meter_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          cellStart,
  input  logic          refStrobe,
  input  logic          countFull,
  output meterStrobes_t strobes
);
  meterState_t state, stateNext;

  always_comb begin
    strobes   = '0;
    stateNext = state;
    if (cellStart) begin
      strobes.clrCnt = 1'b1;
      stateNext      = ST_RUN;
    end else if (state == ST_RUN) begin
      if (refStrobe) begin
        strobes.capture = 1'b1;
        stateNext       = ST_IDLE;
      end else if (!countFull) begin
        strobes.incCnt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/phase_meter_dp.sv
module phase_meter_dp
  import phase_meter_pkg::*;
#(
  parameter int COARSE_W = 9,
  parameter int FINE_TAPS = 4,
  localparam int FINE_W = $clog2(FINE_TAPS),
  localparam int WORD_W = COARSE_W + FINE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  meterStrobes_t        strobes,
  input  logic [FINE_TAPS-1:0] fineTaps,
  output logic                 countFull,
  output logic [WORD_W-1:0]    ctrlWord,
  output logic                 ctrlValid,
  output logic                 fineErr
);
  logic [COARSE_W-1:0] coarseCnt;
  logic [FINE_W-1:0]   fineCode;
  logic                fineIllegal;

  assign countFull = &coarseCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coarseCnt <= '0;
    end else if (strobes.clrCnt) begin
      coarseCnt <= '0;
    end else if (strobes.incCnt) begin
      coarseCnt <= coarseCnt + COARSE_W'(1);
    end
  end

  fine_therm_enc #(.TAPS(FINE_TAPS)) u_fineEnc (
    .taps    (fineTaps),
    .code    (fineCode),
    .illegal (fineIllegal)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlWord  <= '0;
      ctrlValid <= 1'b0;
      fineErr   <= 1'b0;
    end else begin
      ctrlValid <= strobes.capture;
      if (strobes.capture) begin
        ctrlWord <= {coarseCnt, fineCode};
        fineErr  <= fineIllegal;
      end
    end
  end
endmodule

// File: rtl/cell_phase_meter.sv
module cell_phase_meter
  import phase_meter_pkg::*;
#(
  parameter int COARSE_W = 9,
  parameter int FINE_TAPS = 4,
  localparam int FINE_W = $clog2(FINE_TAPS),
  localparam int WORD_W = COARSE_W + FINE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cellStart,
  input  logic                 refStrobe,
  input  logic [FINE_TAPS-1:0] fineTaps,
  output logic [WORD_W-1:0]    ctrlWord,
  output logic                 ctrlValid,
  output logic                 fineErr
);
  meterStrobes_t strobes;
  logic          countFull;

  phase_meter_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cellStart (cellStart),
    .refStrobe (refStrobe),
    .countFull (countFull),
    .strobes   (strobes)
  );

  phase_meter_dp #(.COARSE_W(COARSE_W), .FINE_TAPS(FINE_TAPS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .fineTaps  (fineTaps),
    .countFull (countFull),
    .ctrlWord  (ctrlWord),
    .ctrlValid (ctrlValid),
    .fineErr   (fineErr)
  );
endmodule

// File: rtl/cell_phase_meter_chk.sv
module cell_phase_meter_chk #(
  parameter int WORD_W = 11,
  parameter int FINE_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              cellStart,
  input logic              refStrobe,
  input logic [WORD_W-1:0] ctrlWord,
  input logic              ctrlValid,
  input logic              fineErr
);
  // R3
  valid_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlValid |=> !ctrlValid);

  // R8
  valid_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlValid |-> ($past(refStrobe) && !$past(cellStart)));

  // R7
  word_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlValid |-> ($stable(ctrlWord) && $stable(fineErr)));

  // R5
  err_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    fineErr |-> (ctrlWord[FINE_W-1:0] == '0));
endmodule

bind cell_phase_meter cell_phase_meter_chk #(.WORD_W(WORD_W), .FINE_W(FINE_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cellStart (cellStart),
  .refStrobe (refStrobe),
  .ctrlWord  (ctrlWord),
  .ctrlValid (ctrlValid),
  .fineErr   (fineErr)
);

// File: tb/test_cell_phase_meter.sv
module test_cell_phase_meter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cellStart = 1'b0;
  logic        refStrobe = 1'b0;
  logic [3:0]  fineTaps = 4'b0000;
  logic [10:0] ctrlWord;
  logic        ctrlValid;
  logic        fineErr;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  cell_phase_meter i_cell_phase_meter (
    .clk       (clk),
    .rstN      (rstN),
    .cellStart (cellStart),
    .refStrobe (refStrobe),
    .fineTaps  (fineTaps),
    .ctrlWord  (ctrlWord),
    .ctrlValid (ctrlValid),
    .fineErr   (fineErr)
  );

  // Behavioural reference model
  int mArmed = 0, mCnt = 0, mWord = 0, mValid = 0, mErr = 0;

  function automatic int fineModel(input logic [3:0] t, output int err);
    int ones = 0;
    int gap = 0;
    err = 0;
    for (int i = 0; i < 4; i++) begin
      if (t[i]) begin
        ones++;
        if (gap) err = 1;
      end else begin
        gap = 1;
      end
    end
    if (err || ones == 0) return 0;
    return ones - 1;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mArmed = 0; mCnt = 0; mWord = 0; mValid = 0; mErr = 0;
    end else if (cellStart) begin
      mArmed = 1; mCnt = 0; mValid = 0;
    end else if (mArmed && refStrobe) begin
      int e;
      int f;
      f = fineModel(fineTaps, e);
      mWord = mCnt * 4 + f; mErr = e; mValid = 1; mArmed = 0;
    end else begin
      mValid = 0;
      if (mArmed && mCnt < 511) mCnt++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Model comparison on every clock (R2 R3 R6 R7 R9)
  always @(negedge clk) begin
    if (rstN) begin
      chk("R9 model word", int'(ctrlWord), mWord);
      chk("R3 model valid", int'(ctrlValid), mValid);
      chk("R5 model err", int'(fineErr), mErr);
    end
  end

  // Pulse cellStart, wait, then pulse refStrobe k cycles later
  task automatic runCell(input int k, input logic [3:0] taps);
    @(negedge clk); cellStart = 1'b1;
    @(negedge clk); cellStart = 1'b0;
    repeat (k - 1) @(negedge clk);
    refStrobe = 1'b1; fineTaps = taps;
    @(negedge clk); refStrobe = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 word in reset", int'(ctrlWord), 0);
    chk("R1 valid in reset", int'(ctrlValid), 0);
    chk("R1 err in reset", int'(fineErr), 0);
    rstN = 1'b1;

    // R2 R4: shortest cell, pattern 1000 (only fineTaps[0] set)
    runCell(1, 4'b0001);
    chk("R3 valid pulse", int'(ctrlValid), 1);
    chk("R2 coarse k=1", int'(ctrlWord[10:2]), 0);
    chk("R4 fine 1000", int'(ctrlWord[1:0]), 0);
    @(negedge clk);
    chk("R3 pulse one cycle", int'(ctrlValid), 0);

    // R4 each thermometer pattern
    runCell(5, 4'b0011);
    chk("R2 coarse k=5", int'(ctrlWord[10:2]), 4);
    chk("R4 fine 1100", int'(ctrlWord[1:0]), 1);
    runCell(9, 4'b0111);
    chk("R4 fine 1110", int'(ctrlWord[1:0]), 2);
    runCell(13, 4'b1111);
    chk("R4 fine 1111", int'(ctrlWord[1:0]), 3);
    chk("R9 word value", int'(ctrlWord), 12 * 4 + 3);
    runCell(3, 4'b0000);
    chk("R4 fine 0000", int'(ctrlWord[1:0]), 0);
    chk("R5 valid clears err", int'(fineErr), 0);

    // R5 illegal pattern 0100
    runCell(7, 4'b0010);
    chk("R5 err set", int'(fineErr), 1);
    chk("R5 code zero", int'(ctrlWord[1:0]), 0);
    chk("R2 coarse with err", int'(ctrlWord[10:2]), 6);

    // R7 unarmed ref ignored
    repeat (2) @(negedge clk);
    refStrobe = 1'b1; fineTaps = 4'b1111;
    @(negedge clk); refStrobe = 1'b0;
    chk("R7 no pulse unarmed", int'(ctrlValid), 0);
    chk("R7 word held", int'(ctrlWord), 6 * 4);
    chk("R7 err held", int'(fineErr), 1);

    // R6 saturation
    runCell(700, 4'b0111);
    chk("R6 saturated coarse", int'(ctrlWord[10:2]), 511);
    chk("R6 saturated word", int'(ctrlWord), 511 * 4 + 2);

    // R8 coincident start and ref: restart wins
    @(negedge clk); cellStart = 1'b1; refStrobe = 1'b1; fineTaps = 4'b0001;
    @(negedge clk); cellStart = 1'b0; refStrobe = 1'b0;
    chk("R8 no capture", int'(ctrlValid), 0);
    @(negedge clk);
    refStrobe = 1'b1; fineTaps = 4'b0011;
    @(negedge clk); refStrobe = 1'b0;
    chk("R8 capture after restart", int'(ctrlValid), 1);
    chk("R8 coarse restarted", int'(ctrlWord[10:2]), 1);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule